// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block holds signed conversion results until a host reads them. Each result has 13 bits: a 12-bit magnitude with its sign at bit 12. It is stored as a 16-bit word. The three bits above the sign carry one of two things, picked by a mask input at the moment the result is written. With the mask set, they are copies of the sign, which gives a plain sign-extended value. With the mask clear, they carry the 3-bit pointer of the instruction that produced the result, so software can tell which sequence step each sample came from.

The queue holds 32 words. It reports its fill level and empty and full flags. It also raises a threshold flag whenever the number of stored results equals a programmed 5-bit level. A level of zero turns that flag off. The read side is a simple pop port with a registered data output. Results that arrive while the queue is full are discarded, and a sticky overflow flag records the loss.

Top module: `tagres_fifo`

## Requirements
- R1: After a synchronous reset, fill_count is 0, empty is 1, full, thr_hit and ovf_flag are 0, and rd_data is 0.
- R2: When tag_mask is 1 at the push, the stored word is {3 copies of in_result[12], in_result[12:0]}.
- R3: When tag_mask is 0 at the push, the stored word is {in_iptr[2:0], in_result[12:0]}.
- R4: A change of tag_mask after a word is stored does not change that word when it is later read.
- R5: Words leave in the order they were accepted. A pop on a non-empty queue puts the oldest word on rd_data one cycle later.
- R6: fill_count goes up by one for each accepted push and down by one for each accepted pop, one cycle after the request. empty is 1 exactly at count 0, and full is 1 exactly at count 32.
- R7: For thr_level between 1 and 31, thr_hit is 1 in exactly those cycles where fill_count equals thr_level.
- R8: With thr_level equal to 0, thr_hit stays 0 at every fill level.
- R9: A push to a full queue without a pop in the same cycle is dropped, and the count stays at 32. It sets ovf_flag, which stays 1 until reset.
- R10: A pop on an empty queue leaves rd_data and fill_count unchanged.
- R11: A push and a pop in the same cycle on a non-empty queue leave fill_count unchanged. This includes a full queue, where the push is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Result strobe (push request) |
| in_result | input | 13 | Signed result, sign at bit 12 |
| in_iptr | input | 3 | Pointer of the producing instruction |
| tag_mask | input | 1 | 1: sign copies in the top bits, 0: instruction tag |
| thr_level | input | 5 | Occupancy level for thr_hit; 0 disables it |
| rd_pop | input | 1 | Pop request |
| rd_data | output | 16 | Registered word from the last accepted pop |
| fill_count | output | 6 | Number of stored words |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds 32 words |
| thr_hit | output | 1 | fill_count equals a non-zero thr_level |
| ovf_flag | output | 1 | Sticky: a push was dropped |

## Verification
A wrong pointer or count shows at the ports within one cycle of the faulty update. It appears as a fill_count or flag mismatch, or as a rd_data word out of order on the next pop. A wrong tag decision shows only when that word is popped, which may be up to 32 pops later. For that reason the bench drains the queue completely after each pattern. Threshold and overflow faults show in the cycle after the push that reaches the level or meets a full queue.

// File: rtl/tagres_pkg.sv
package tagres_pkg;
  localparam int RES_W_DEF   = 13;
  localparam int TAG_W_DEF   = 3;
  localparam int DEPTH_DEF   = 32;
  localparam int THR_W_DEF   = 5;

  typedef struct packed {
    logic push;
    logic pop;
  } xfer_t;
endpackage

// File: rtl/tagres_pack.sv
module tagres_pack #(
  parameter int RES_W = 13,
  parameter int TAG_W = 3
) (
  input  logic [RES_W-1:0]       res,
  input  logic [TAG_W-1:0]       iptr,
  input  logic                   mask,
  output logic [RES_W+TAG_W-1:0] word
);
  always_comb begin
    if (mask) word = {{TAG_W{res[RES_W-1]}}, res};
    else      word = {iptr, res};
  end
endmodule

// File: rtl/tagres_mem.sv
module tagres_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tagres_ctrl.sv
module tagres_ctrl
  import tagres_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int THR_W = 5,
  parameter int AW    = 5,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [THR_W-1:0] thr_level,
  output xfer_t            xfer,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             thr_hit,
  output logic             ovf
);
  logic [CW-1:0] cnt_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    xfer.pop  = pop_req && !empty;
    xfer.push = push_req && (!full || xfer.pop);
    cnt_nxt   = count + CW'(xfer.push) - CW'(xfer.pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      empty   <= 1'b1;
      full    <= 1'b0;
      thr_hit <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (xfer.push) wptr <= bump(wptr);
      if (xfer.pop)  rptr <= bump(rptr);
      count   <= cnt_nxt;
      empty   <= (cnt_nxt == '0);
      full    <= (cnt_nxt == CW'(DEPTH));
      thr_hit <= (thr_level != '0) && (cnt_nxt == CW'(thr_level));
      if (push_req && !xfer.push) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/tagres_fifo.sv
module tagres_fifo
  import tagres_pkg::*;
#(
  parameter int RES_W = RES_W_DEF,
  parameter int TAG_W = TAG_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  parameter int THR_W = THR_W_DEF,
  localparam int WORD_W = RES_W + TAG_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [RES_W-1:0]  in_result,
  input  logic [TAG_W-1:0]  in_iptr,
  input  logic              tag_mask,
  input  logic [THR_W-1:0]  thr_level,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     fill_count,
  output logic              empty,
  output logic              full,
  output logic              thr_hit,
  output logic              ovf_flag
);
  xfer_t             xfer;
  logic [AW-1:0]     wptr, rptr;
  logic [WORD_W-1:0] wword;

  tagres_pack #(.RES_W(RES_W), .TAG_W(TAG_W)) u_pack (
    .res(in_result), .iptr(in_iptr), .mask(tag_mask), .word(wword)
  );

  tagres_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(in_valid), .pop_req(rd_pop),
    .thr_level(thr_level), .xfer(xfer), .wptr(wptr), .rptr(rptr),
    .count(fill_count), .empty(empty), .full(full),
    .thr_hit(thr_hit), .ovf(ovf_flag)
  );

  tagres_mem #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(xfer.push), .waddr(wptr), .wdata(wword),
    .re(xfer.pop), .raddr(rptr), .rdata(rd_data)
  );
endmodule

// File: rtl/tagres_fifo_chk.sv
module tagres_fifo_chk #(
  parameter int WORD_W = 16,
  parameter int CW     = 6,
  parameter int THR_W  = 5,
  parameter int DEPTH  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              rd_pop,
  input logic [THR_W-1:0]  thr_level,
  input logic [WORD_W-1:0] rd_data,
  input logic [CW-1:0]     fill_count,
  input logic              empty,
  input logic              full,
  input logic              thr_hit,
  input logic              ovf_flag
);
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    empty |-> (fill_count == '0));
  a_r6_push_inc: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rd_pop && !full) |=> (fill_count == $past(fill_count) + 1'b1));
  a_r7_thr_match: assert property (@(posedge clk) disable iff (rst)
    thr_hit |-> (fill_count == CW'($past(thr_level))));
  a_r8_thr_off: assert property (@(posedge clk) disable iff (rst)
    (thr_level == '0) |=> !thr_hit);
  a_r9_drop_full: assert property (@(posedge clk) disable iff (rst)
    (full && in_valid && !rd_pop) |=> (full && ovf_flag));
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_pop && !in_valid) |=> (empty && $stable(rd_data)));
  a_r11_both: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_pop && !empty) |=> $stable(fill_count));
endmodule

bind tagres_fifo tagres_fifo_chk #(.WORD_W(WORD_W), .CW(CW), .THR_W(THR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rd_pop(rd_pop), .thr_level(thr_level),
  .rd_data(rd_data), .fill_count(fill_count), .empty(empty), .full(full),
  .thr_hit(thr_hit), .ovf_flag(ovf_flag)
);

// File: tb/sim_tagres_fifo.sv
module sim_tagres_fifo;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [12:0] in_result = '0;
  logic [2:0]  in_iptr = '0;
  logic        tag_mask = 1'b1;
  logic [4:0]  thr_level = '0;
  logic        rd_pop = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  fill_count;
  logic        empty, full, thr_hit, ovf_flag;

  always #2 clk = ~clk;

  tagres_fifo u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_result(in_result),
    .in_iptr(in_iptr), .tag_mask(tag_mask), .thr_level(thr_level),
    .rd_pop(rd_pop), .rd_data(rd_data), .fill_count(fill_count),
    .empty(empty), .full(full), .thr_hit(thr_hit), .ovf_flag(ovf_flag)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  logic [15:0] q[$];
  logic [15:0] last_rd = '0;
  logic        ovf_m = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [12:0] r, input logic [2:0] ip, input logic p);
    logic [15:0] w;
    bit dp, dpush, hit;
    @(negedge clk);
    in_valid = v; in_result = r; in_iptr = ip; rd_pop = p;
    dp    = p && (q.size() > 0);
    dpush = v && ((q.size() < DEPTH) || dp);
    w     = tag_mask ? {{3{r[12]}}, r} : {ip, r};
    if (dp)         last_rd = q.pop_front();
    if (dpush)      q.push_back(w);
    if (v && !dpush) ovf_m = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; rd_pop = 1'b0;
    hit = (thr_level != 0) && (q.size() == thr_level);
    chk("R5 rd_data", rd_data, last_rd);
    chk("R6 fill_count", fill_count, q.size());
    chk("R6 empty", empty, q.size() == 0);
    chk("R6 full", full, q.size() == DEPTH);
    chk("R7 thr_hit", thr_hit, hit);
    chk("R9 ovf_flag", ovf_flag, ovf_m);
  endtask

  task automatic drain();
    while (q.size() > 0) step(1'b0, '0, '0, 1'b1);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 count", fill_count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 thr_hit", thr_hit, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_sign();
    tag_mask = 1'b1;
    step(1'b1, 13'h1abc, 3'd5, 1'b0);
    step(1'b1, 13'h0123, 3'd2, 1'b0);
    step(1'b0, '0, '0, 1'b1);
    chk("R2 negative", rd_data, 16'hfabc);
    step(1'b0, '0, '0, 1'b1);
    chk("R2 positive", rd_data, 16'h0123);
  endtask

  task automatic t_tag();
    tag_mask = 1'b0;
    step(1'b1, 13'h1abc, 3'd5, 1'b0);
    step(1'b1, 13'h0123, 3'd2, 1'b0);
    step(1'b0, '0, '0, 1'b1);
    chk("R3 tag5", rd_data, 16'hbabc);
    step(1'b0, '0, '0, 1'b1);
    chk("R3 tag2", rd_data, 16'h4123);
  endtask

  task automatic t_mask_change();
    tag_mask = 1'b0;
    step(1'b1, 13'h0123, 3'd7, 1'b0);
    tag_mask = 1'b1;
    step(1'b0, '0, '0, 1'b0);
    step(1'b0, '0, '0, 1'b1);
    chk("R4 stored tag kept", rd_data, 16'he123);
  endtask

  task automatic t_fill();
    tag_mask  = 1'b0;
    thr_level = 5'd5;
    for (int i = 0; i < DEPTH; i++) step(1'b1, 13'(i * 37 + 1), 3'(i), 1'b0);
    chk("R6 full at 32", full, 1);
    chk("R9 no ovf yet", ovf_flag, 0);
    step(1'b1, 13'h0555, 3'd1, 1'b0);
    chk("R9 drop count", fill_count, DEPTH);
    chk("R9 ovf set", ovf_flag, 1);
    step(1'b1, 13'h0777, 3'd3, 1'b1);
    chk("R11 full both", fill_count, DEPTH);
    drain();
    chk("R6 empty after drain", empty, 1);
    chk("R9 ovf sticky", ovf_flag, 1);
  endtask

  task automatic t_empty_pop();
    logic [15:0] held;
    held = rd_data;
    step(1'b0, '0, '0, 1'b1);
    chk("R10 data held", rd_data, held);
    chk("R10 count held", fill_count, 0);
  endtask

  task automatic t_thr_zero();
    thr_level = 5'd0;
    tag_mask  = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 13'(i + 100), 3'd0, 1'b0);
      chk("R8 thr off", thr_hit, 0);
    end
    step(1'b1, 13'h1001, 3'd0, 1'b1);
    chk("R11 mid both", fill_count, 4);
    thr_level = 5'd3;
    drain();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sign();
        t_tag();
        t_mask_change();
        t_fill();
        t_empty_pop();
        t_thr_zero();
      end
      begin
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule